// File: doc/BRIEF.md
# Condition Gate for Instruction Retirement

This block sits between instruction decode and writeback. It decides, for each instruction, whether that instruction takes effect. The top four bits of the instruction word select one of sixteen conditions. The block tests the selected condition against the current negative, zero, carry and overflow flags. The result is an execute-enable.

The decoder also reports whether the instruction wants to write a register and whether it wants to update the flags. When the condition fails, both of those requests are dropped, so the instruction does nothing. It still moves on and retires. The always-true code covers instructions that carry no condition. The never-true code turns any instruction into a no-operation. Conditional branches come from this same mechanism applied to a plain branch.

Inputs are qualified by a valid bit. The result leaves through one register stage, and the valid bit travels beside it.

Top module: `cond_exec_gate`

## Requirements
- R1: The condition code is bits [31:28] of the instruction word. No other instruction bit affects the execute-enable.
- R2: Code 0000 executes when Z=1. Code 0001 executes when Z=0. The flag input is ordered {N,Z,C,V}, bit 3 down to bit 0.
- R3: Code 0010 executes when C=1 and code 0011 when C=0. Code 0100 executes when N=1 and code 0101 when N=0. Code 0110 executes when V=1 and code 0111 when V=0.
- R4: Code 1000 executes when C=1 and Z=0. Code 1001 executes when C=0 or Z=1.
- R5: Code 1010 executes when N equals V. Code 1011 executes when N differs from V.
- R6: Code 1100 executes when Z=0 and N equals V. Code 1101 executes when Z=1 or N differs from V.
- R7: Code 1110 executes for every flag value. Code 1111 never executes.
- R8: A valid input appears on the outputs exactly one clock later. out_valid is high in that cycle and out_instr carries the same instruction word.
- R9: out_wb_en equals the execute-enable ANDed with in_wb_req. out_flag_en equals the execute-enable ANDed with in_flag_req. out_retire is high for every valid instruction, whether it passed or failed.
- R10: One clock after a cycle with in_valid low, out_valid, out_exec, out_wb_en, out_flag_en and out_retire are all low, whatever the other inputs were.
- R11: While reset is held, and until the first valid input has been registered, out_valid and all enables are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input instruction is valid |
| in_instr | input | 32 | Instruction word; condition in [31:28] |
| in_flags | input | 4 | Status flags {N,Z,C,V} |
| in_wb_req | input | 1 | Instruction requests register writeback |
| in_flag_req | input | 1 | Instruction requests flag update |
| out_valid | output | 1 | Registered valid |
| out_instr | output | 32 | Registered instruction word |
| out_exec | output | 1 | Condition passed |
| out_wb_en | output | 1 | Writeback permitted |
| out_flag_en | output | 1 | Flag update permitted |
| out_retire | output | 1 | Instruction retires (passed or squashed) |

## Verification
The bench drives every one of the sixteen codes against all sixteen flag combinations, with varied low instruction bits and varied writeback and flag requests. This sweep catches a swapped pair, where for example greater-than and less-or-equal are exchanged. It also catches a signed comparison that reads carry instead of overflow, and a never code that opens an instruction space instead of squashing. Two further cases are driven on purpose. Idle cycles carry conditions that would pass, which catches a design that lets stale or unqualified data raise an enable. A squashed instruction that requests writeback catches a design that leaks the write or drops the retire.

// File: rtl/cond_pkg.sv
package cond_pkg;

  localparam int COND_W  = 4;
  localparam int FLAGS_W = 4;

  typedef enum logic [COND_W-1:0] {
    CC_EQ = 4'b0000, CC_NE = 4'b0001,
    CC_CS = 4'b0010, CC_CC = 4'b0011,
    CC_MI = 4'b0100, CC_PL = 4'b0101,
    CC_VS = 4'b0110, CC_VC = 4'b0111,
    CC_HI = 4'b1000, CC_LS = 4'b1001,
    CC_GE = 4'b1010, CC_LT = 4'b1011,
    CC_GT = 4'b1100, CC_LE = 4'b1101,
    CC_AL = 4'b1110, CC_NV = 4'b1111
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

endpackage

// File: rtl/cond_rst_sync.sv
module cond_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/cond_evaluator.sv
module cond_evaluator
  import cond_pkg::*;
(
  input  cond_e  cond,
  input  flags_t flags,
  output logic   pass
);

  logic [COND_W-1:0] code;
  logic              base;
  logic              nv_eq;

  always_comb begin
    code  = cond;
    nv_eq = (flags.n == flags.v);
    // each even code has a base test; the odd partner is its inverse
    unique case (code[COND_W-1:1])
      3'd0:    base = flags.z;
      3'd1:    base = flags.c;
      3'd2:    base = flags.n;
      3'd3:    base = flags.v;
      3'd4:    base = flags.c & ~flags.z;
      3'd5:    base = nv_eq;
      3'd6:    base = ~flags.z & nv_eq;
      default: base = 1'b1;
    endcase
    pass = base ^ code[0];
  end

endmodule

// File: rtl/cond_output_stage.sv
module cond_output_stage #(
  parameter int INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] in_instr,
  input  logic               in_pass,
  input  logic               in_wb_req,
  input  logic               in_flag_req,
  output logic               out_valid,
  output logic [INSTR_W-1:0] out_instr,
  output logic               out_exec,
  output logic               out_wb_en,
  output logic               out_flag_en,
  output logic               out_retire
);

  logic               valid_q;
  logic               valid_d;
  logic [INSTR_W-1:0] instr_q;
  logic [INSTR_W-1:0] instr_d;
  logic               exec_q, exec_d;
  logic               wb_q, wb_d;
  logic               fl_q, fl_d;
  logic               load_en;

  always_comb begin
    load_en = in_valid;
    valid_d = in_valid;
    instr_d = in_instr;
    exec_d  = in_pass;
    wb_d    = in_pass & in_wb_req;
    fl_d    = in_pass & in_flag_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instr_q <= '0;
      exec_q  <= 1'b0;
      wb_q    <= 1'b0;
      fl_q    <= 1'b0;
    end else if (load_en) begin
      instr_q <= instr_d;
      exec_q  <= exec_d;
      wb_q    <= wb_d;
      fl_q    <= fl_d;
    end
  end

  assign out_valid   = valid_q;
  assign out_instr   = instr_q;
  assign out_exec    = valid_q & exec_q;
  assign out_wb_en   = valid_q & wb_q;
  assign out_flag_en = valid_q & fl_q;
  assign out_retire  = valid_q;

endmodule

// File: rtl/cond_exec_gate.sv
module cond_exec_gate
  import cond_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] in_instr,
  input  logic [3:0]         in_flags,
  input  logic               in_wb_req,
  input  logic               in_flag_req,
  output logic               out_valid,
  output logic [INSTR_W-1:0] out_instr,
  output logic               out_exec,
  output logic               out_wb_en,
  output logic               out_flag_en,
  output logic               out_retire
);

  localparam int COND_LSB = INSTR_W - COND_W;

  logic   rst_sync_n;
  cond_e  cond;
  flags_t flags;
  logic   pass;

  assign cond  = cond_e'(in_instr[INSTR_W-1:COND_LSB]);
  assign flags = flags_t'(in_flags);

  cond_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cond_evaluator u_eval (
    .cond  (cond),
    .flags (flags),
    .pass  (pass)
  );

  cond_output_stage #(.INSTR_W(INSTR_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .in_valid    (in_valid),
    .in_instr    (in_instr),
    .in_pass     (pass),
    .in_wb_req   (in_wb_req),
    .in_flag_req (in_flag_req),
    .out_valid   (out_valid),
    .out_instr   (out_instr),
    .out_exec    (out_exec),
    .out_wb_en   (out_wb_en),
    .out_flag_en (out_flag_en),
    .out_retire  (out_retire)
  );

endmodule

// File: rtl/cond_exec_gate_chk.sv
module cond_exec_gate_chk #(
  parameter int INSTR_W = 32
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               in_valid,
  input logic [INSTR_W-1:0] in_instr,
  input logic [3:0]         in_flags,
  input logic               out_valid,
  input logic [INSTR_W-1:0] out_instr,
  input logic               out_exec,
  input logic               out_wb_en,
  input logic               out_flag_en,
  input logic               out_retire
);

  logic       seen;
  logic [3:0] oc;

  assign oc = out_instr[INSTR_W-1:INSTR_W-4];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) seen <= 1'b0;
    else             seen <= 1'b1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !out_valid |-> !(out_exec || out_wb_en || out_flag_en || out_retire)); // R10

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    seen |-> out_valid == $past(in_valid)); // R8

  AST_INSTR_CARRY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seen && $past(in_valid)) |-> out_instr == $past(in_instr)); // R8

  AST_NEVER_CODE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && oc == 4'hF) |-> !out_exec); // R7

  AST_ALWAYS_CODE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && oc == 4'hE) |-> out_exec); // R7

  AST_SQUASH_SILENT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !out_exec) |-> (!out_wb_en && !out_flag_en && out_retire)); // R9

  AST_EQ_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seen && out_valid && oc == 4'h0) |-> out_exec == $past(in_flags[2])); // R2

endmodule

bind cond_exec_gate cond_exec_gate_chk #(.INSTR_W(INSTR_W)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .in_valid    (in_valid),
  .in_instr    (in_instr),
  .in_flags    (in_flags),
  .out_valid   (out_valid),
  .out_instr   (out_instr),
  .out_exec    (out_exec),
  .out_wb_en   (out_wb_en),
  .out_flag_en (out_flag_en),
  .out_retire  (out_retire)
);

// File: tb/test_cond_exec_gate.sv
`timescale 1ns/1ps
module test_cond_exec_gate;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_instr;
  logic [3:0]  in_flags;
  logic        in_wb_req;
  logic        in_flag_req;
  logic        out_valid;
  logic [31:0] out_instr;
  logic        out_exec;
  logic        out_wb_en;
  logic        out_flag_en;
  logic        out_retire;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic        valid;
    logic        exec;
    logic        wb;
    logic        fl;
    logic [31:0] instr;
    string       req;
  } exp_t;

  exp_t sbq[$];

  always #5 clk = ~clk;

  cond_exec_gate i_cond_exec_gate (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .in_flags(in_flags), .in_wb_req(in_wb_req), .in_flag_req(in_flag_req),
    .out_valid(out_valid), .out_instr(out_instr), .out_exec(out_exec),
    .out_wb_en(out_wb_en), .out_flag_en(out_flag_en), .out_retire(out_retire)
  );

  function automatic logic ref_pass(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !cy || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] c);
    if (c < 2)       return "R2";
    else if (c < 8)  return "R3";
    else if (c < 10) return "R4";
    else if (c < 12) return "R5";
    else if (c < 14) return "R6";
    else             return "R7";
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic v, input logic [31:0] instr, input logic [3:0] f,
                      input logic wb, input logic fl, input string req);
    exp_t e;
    logic p;
    @(negedge clk);
    in_valid    = v;
    in_instr    = instr;
    in_flags    = f;
    in_wb_req   = wb;
    in_flag_req = fl;
    p = ref_pass(instr[31:28], f);
    e.valid = v;
    e.exec  = v && p;
    e.wb    = v && p && wb;
    e.fl    = v && p && fl;
    e.instr = instr;
    e.req   = v ? req : "R10";
    sbq.push_back(e);
  endtask

  // monitor: compares one cycle after each drive
  always @(posedge clk) begin
    #2;
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      check("R8", "out_valid", 32'(out_valid), 32'(e.valid));
      check(e.req, "out_exec", 32'(out_exec), 32'(e.exec));
      check("R9", "out_wb_en", 32'(out_wb_en), 32'(e.wb));
      check("R9", "out_flag_en", 32'(out_flag_en), 32'(e.fl));
      check("R9", "out_retire", 32'(out_retire), 32'(e.valid));
      if (e.valid) check("R8", "out_instr", out_instr, e.instr);
    end
  end

  initial begin
    #500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b1; in_instr = 32'hE000_0000; in_flags = 4'h0;
    in_wb_req = 1'b1; in_flag_req = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    // R11: reset holds all outputs low even with valid input applied
    check("R11", "reset out_valid", 32'(out_valid), 0);
    check("R11", "reset enables", 32'({out_exec, out_wb_en, out_flag_en, out_retire}), 0);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check("R11", "post-reset out_valid", 32'(out_valid), 0);

    // R1: low bits do not influence the condition
    send(1, 32'h0FFF_FFFF, 4'b0100, 1, 1, "R1");
    send(1, 32'h0000_0000, 4'b0000, 1, 1, "R1");
    send(1, 32'hF000_0000, 4'b1111, 1, 1, "R1");
    send(1, 32'h1FFF_FFFF, 4'b0000, 0, 1, "R1");

    // all codes against all flag combinations, with idle cycles between codes
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        logic [31:0] w;
        w = {c[3:0], 28'(32'h00A5_C3F1 * (f + 1))};
        send(1, w, f[3:0], f[0] ^ c[0], f[1], req_of(c[3:0]));
      end
      // R10: idle cycle with a passing condition must stay silent
      send(0, 32'hE123_4567, 4'hF, 1, 1, "R10");
    end

    // R9: squashed instruction requesting both writes
    send(1, 32'hF00D_0001, 4'b0000, 1, 1, "R9");
    send(1, 32'h0BAD_0002, 4'b0000, 1, 1, "R9");
    // back-to-back then idle
    send(1, 32'hE000_0003, 4'b1010, 1, 0, "R7");
    send(0, 32'h0000_0000, 4'b0100, 1, 1, "R10");
    send(0, 32'h0000_0000, 4'b0100, 1, 1, "R10");
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule